// File: doc/BRIEF.md
# Host Port Master Sequencer

This block sits on the host side of a 16-bit slave host port and turns whole 32-bit operations into the halfword strobe sequences that port expects. A requester hands it one command at a time over a valid/ready pair. The five commands are: write the port's control word, load the port's address register, write one word, read one word, and read a burst of consecutive words with address auto-increment. The block then drives the select code, read/write level, halfword flag, write data and active-low strobe. It paces each strobe against the slave's not-ready line and returns every assembled read word on a result port.

The order in which the two halves travel follows a half-order bit. The sequencer captures this bit from bit 0 of every control-word write and uses it for all later address, data and burst transfers. A value of 1 sends the low half first. A value of 0, which is also the reset value, sends the high half first. The strobe width is set by a parameter. A second parameter bounds how long the slave may hold not-ready before the command is abandoned and reported.

Top module: `hpm_seq`

## Requirements
- R1: After reset, cmd_ready is 1, hp_strobe_n is 1, hp_drive is 0, res_valid is 0 and err_timeout is 0.
- R2: Opcode 0 (control write) makes two strobes with hp_sel = 00 and hp_rnw = 0. Both halves carry cmd_data[15:0]. Bit 0 of that value becomes the half order: 1 means low half first, 0 means high half first.
- R3: Opcode 1 (address load) makes two strobes with hp_sel = 01 and hp_rnw = 0. cmd_data is split in the current half order, and hp_half is 0 on the first strobe and 1 on the second.
- R4: Opcode 2 (word write) makes two strobes with hp_sel = 11 and hp_rnw = 0. The halves of cmd_data go out in the current half order.
- R5: Opcode 3 (word read) makes two strobes with hp_sel = 11 and hp_rnw = 1. Each strobe's hp_rdata is placed in the half chosen by the current order, and the assembled word is shown on res_data for exactly one res_valid cycle.
- R6: Opcode 4 (burst read) reads cmd_len+1 words (1 to 256) with hp_sel = 10 and hp_rnw = 1. It gives one res_valid pulse per word, in address order.
- R7: hp_strobe_n is low for exactly STROBE_CYCLES cycles per halfword. hp_sel, hp_rnw, hp_half and hp_wdata do not change from the cycle before the strobe falls through the cycle after it rises.
- R8: While hp_busy is high and the strobe is inactive, no new strobe starts in the next cycle. Read data is taken only in a cycle where hp_busy is low.
- R9: cmd_ready falls in the cycle after a command is accepted and stays low until the last halfword of that command has completed.
- R10: If hp_busy stays high for TIMEOUT_CYCLES consecutive cycles while a halfword is waiting, err_timeout pulses for one cycle. The command is abandoned with no result, and cmd_ready returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle and able to accept |
| cmd_op | input | 3 | Opcode: 0 control, 1 address, 2 write, 3 read, 4 burst |
| cmd_data | input | 32 | Control value, address or write word |
| cmd_len | input | 8 | Burst word count minus one |
| hp_sel | output | 2 | Register select code to the slave port |
| hp_rnw | output | 1 | 1 read, 0 write |
| hp_half | output | 1 | 0 first halfword, 1 second halfword |
| hp_strobe_n | output | 1 | Active-low access strobe |
| hp_drive | output | 1 | High while the host drives the data lines |
| hp_wdata | output | 16 | Halfword driven to the slave |
| hp_rdata | input | 16 | Halfword returned by the slave |
| hp_busy | input | 1 | Slave not-ready |
| res_valid | output | 1 | One-cycle pulse with a read word |
| res_data | output | 32 | Assembled read word |
| err_timeout | output | 1 | One-cycle pulse when a not-ready wait was abandoned |

## Verification
The hardest state to reach is a halfword wait that runs into the timeout partway through a read. From the ports it looks the same as an ordinary slow slave until the limit is reached. The bench's slave model holds not-ready for a programmable number of cycles after each strobe. The bench sets that delay longer than the limit, then confirms that only one strobe was issued, that no word came back and that the sequencer is idle again. Read order under both half orders and long wrapping bursts are covered by sweeping slave latencies of zero to three cycles across every address of a small slave memory.

// File: rtl/hpm_pkg.sv
package hpm_pkg;

    typedef enum logic [2:0] {
        OP_CTRL  = 3'd0,
        OP_ADDR  = 3'd1,
        OP_WRITE = 3'd2,
        OP_READ  = 3'd3,
        OP_BURST = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_WAIT
    } phase_e;

    localparam logic [1:0] SEL_CTRL = 2'b00;
    localparam logic [1:0] SEL_ADDR = 2'b01;
    localparam logic [1:0] SEL_INC  = 2'b10;
    localparam logic [1:0] SEL_DATA = 2'b11;

endpackage

// File: rtl/hpm_cycle_cnt.sv
module hpm_cycle_cnt #(
    parameter int MAX = 64,
    parameter int W   = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (cnt_q != W'(MAX))
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/hpm_half_mux.sv
module hpm_half_mux #(
    parameter int HALF_W = 16
) (
    input  logic [2*HALF_W-1:0] word,
    input  logic                low_first,
    input  logic                second,
    output logic                pick_high,
    output logic [HALF_W-1:0]   half
);
    assign pick_high = (second == low_first);
    assign half      = pick_high ? word[2*HALF_W-1:HALF_W] : word[HALF_W-1:0];
endmodule

// File: rtl/hpm_seq.sv
module hpm_seq #(
    parameter int HALF_W         = 16,
    parameter int LEN_W          = 8,
    parameter int STROBE_CYCLES  = 2,
    parameter int TIMEOUT_CYCLES = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [2:0]          cmd_op,
    input  logic [2*HALF_W-1:0] cmd_data,
    input  logic [LEN_W-1:0]    cmd_len,
    output logic [1:0]          hp_sel,
    output logic                hp_rnw,
    output logic                hp_half,
    output logic                hp_strobe_n,
    output logic                hp_drive,
    output logic [HALF_W-1:0]   hp_wdata,
    input  logic [HALF_W-1:0]   hp_rdata,
    input  logic                hp_busy,
    output logic                res_valid,
    output logic [2*HALF_W-1:0] res_data,
    output logic                err_timeout
);
    import hpm_pkg::*;

    localparam int WORD_W  = 2 * HALF_W;
    localparam int CNT_MAX = (STROBE_CYCLES > TIMEOUT_CYCLES) ? STROBE_CYCLES : TIMEOUT_CYCLES;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        phase_e              phase;
        logic [1:0]          sel;
        logic                rnw;
        logic                second;
        logic                low_first;
        logic [WORD_W-1:0]   word;
        logic [LEN_W-1:0]    left;
        logic                res_valid;
        logic [WORD_W-1:0]   res_data;
        logic                err;
    } seq_t;

    seq_t d, q;

    logic [CNT_W-1:0]  cnt;
    logic              cnt_clr;
    logic              pick_high;
    logic [HALF_W-1:0] out_half;
    logic [WORD_W-1:0] merged;
    logic              timed_out;
    logic              strobe_done;

    hpm_cycle_cnt #(.MAX(CNT_MAX), .W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .cnt   (cnt)
    );

    hpm_half_mux #(.HALF_W(HALF_W)) u_mux (
        .word      (q.word),
        .low_first (q.low_first),
        .second    (q.second),
        .pick_high (pick_high),
        .half      (out_half)
    );

    assign timed_out   = hp_busy && (cnt == CNT_W'(TIMEOUT_CYCLES - 1));
    assign strobe_done = (cnt == CNT_W'(STROBE_CYCLES - 1));
    assign merged      = pick_high ? {hp_rdata, q.word[HALF_W-1:0]}
                                   : {q.word[WORD_W-1:HALF_W], hp_rdata};

    always_comb begin
        d           = q;
        d.res_valid = 1'b0;
        d.err       = 1'b0;
        unique case (q.phase)
            PH_IDLE: begin
                if (cmd_valid) begin
                    d.second = 1'b0;
                    d.left   = '0;
                    d.word   = cmd_data;
                    d.phase  = PH_SETUP;
                    case (op_e'(cmd_op))
                        OP_CTRL: begin
                            d.sel       = SEL_CTRL;
                            d.rnw       = 1'b0;
                            d.word      = {cmd_data[HALF_W-1:0], cmd_data[HALF_W-1:0]};
                            d.low_first = cmd_data[0];
                        end
                        OP_ADDR: begin
                            d.sel = SEL_ADDR;
                            d.rnw = 1'b0;
                        end
                        OP_WRITE: begin
                            d.sel = SEL_DATA;
                            d.rnw = 1'b0;
                        end
                        OP_READ: begin
                            d.sel = SEL_DATA;
                            d.rnw = 1'b1;
                        end
                        OP_BURST: begin
                            d.sel  = SEL_INC;
                            d.rnw  = 1'b1;
                            d.left = cmd_len;
                        end
                        default: d.phase = PH_IDLE;
                    endcase
                end
            end
            PH_SETUP: begin
                if (timed_out) begin
                    d.err   = 1'b1;
                    d.phase = PH_IDLE;
                end else if (!hp_busy) begin
                    d.phase = PH_STROBE;
                end
            end
            PH_STROBE: begin
                if (strobe_done) d.phase = PH_WAIT;
            end
            PH_WAIT: begin
                if (timed_out) begin
                    d.err   = 1'b1;
                    d.phase = PH_IDLE;
                end else if (!hp_busy) begin
                    if (q.rnw) d.word = merged;
                    if (!q.second) begin
                        d.second = 1'b1;
                        d.phase  = PH_SETUP;
                    end else begin
                        if (q.rnw) begin
                            d.res_valid = 1'b1;
                            d.res_data  = merged;
                        end
                        if (q.left != '0) begin
                            d.left   = q.left - 1'b1;
                            d.second = 1'b0;
                            d.phase  = PH_SETUP;
                        end else begin
                            d.phase = PH_IDLE;
                        end
                    end
                end
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    assign cnt_clr = (d.phase != q.phase);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.phase     <= PH_IDLE;
            q.sel       <= SEL_CTRL;
            q.rnw       <= 1'b1;
            q.second    <= 1'b0;
            q.low_first <= 1'b0;
            q.word      <= '0;
            q.left      <= '0;
            q.res_valid <= 1'b0;
            q.res_data  <= '0;
            q.err       <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign cmd_ready   = (q.phase == PH_IDLE);
    assign hp_sel      = q.sel;
    assign hp_rnw      = q.rnw;
    assign hp_half     = q.second;
    assign hp_strobe_n = (q.phase != PH_STROBE);
    assign hp_drive    = !q.rnw && (q.phase != PH_IDLE);
    assign hp_wdata    = out_half;
    assign res_valid   = q.res_valid;
    assign res_data    = q.res_data;
    assign err_timeout = q.err;
endmodule

// File: rtl/hpm_seq_chk.sv
module hpm_seq_chk #(
    parameter int HALF_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [2:0]        cmd_op,
    input logic [1:0]        hp_sel,
    input logic              hp_rnw,
    input logic              hp_half,
    input logic              hp_strobe_n,
    input logic [HALF_W-1:0] hp_wdata,
    input logic              hp_busy,
    input logic              res_valid,
    input logic              err_timeout
);
    assert_bus_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hp_strobe_n || $past(!hp_strobe_n)) |->
        ($stable(hp_sel) && $stable(hp_rnw) && $stable(hp_half) && $stable(hp_wdata)));

    assert_no_strobe_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_busy && hp_strobe_n) |=> hp_strobe_n);

    assert_ready_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && (cmd_op <= 3'd4)) |=> !cmd_ready);

    assert_strobe_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !hp_strobe_n |-> !cmd_ready);

    assert_err_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |-> (cmd_ready && !res_valid));
endmodule

bind hpm_seq hpm_seq_chk #(.HALF_W(HALF_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_op      (cmd_op),
    .hp_sel      (hp_sel),
    .hp_rnw      (hp_rnw),
    .hp_half     (hp_half),
    .hp_strobe_n (hp_strobe_n),
    .hp_wdata    (hp_wdata),
    .hp_busy     (hp_busy),
    .res_valid   (res_valid),
    .err_timeout (err_timeout)
);

// File: tb/hpm_seq_bench.sv
module hpm_seq_bench;
    localparam int STB = 3;
    localparam int TMO = 40;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid;
    logic        cmd_ready;
    logic [2:0]  cmd_op;
    logic [31:0] cmd_data;
    logic [7:0]  cmd_len;
    logic [1:0]  hp_sel;
    logic        hp_rnw, hp_half, hp_strobe_n, hp_drive;
    logic [15:0] hp_wdata;
    logic [15:0] hp_rdata;
    logic        hp_busy;
    logic        res_valid;
    logic [31:0] res_data;
    logic        err_timeout;

    always #10 clk = ~clk;

    hpm_seq #(.HALF_W(16), .LEN_W(8), .STROBE_CYCLES(STB), .TIMEOUT_CYCLES(TMO)) u_hpm_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_data(cmd_data), .cmd_len(cmd_len),
        .hp_sel(hp_sel), .hp_rnw(hp_rnw), .hp_half(hp_half), .hp_strobe_n(hp_strobe_n),
        .hp_drive(hp_drive), .hp_wdata(hp_wdata), .hp_rdata(hp_rdata), .hp_busy(hp_busy),
        .res_valid(res_valid), .res_data(res_data), .err_timeout(err_timeout)
    );

    // slave model
    int          busy_len;
    int          busy_cnt;
    int          s_total;
    int          stab_err, width_err, r8_err, low_run;
    logic        s_lf;
    logic [31:0] s_addr;
    logic [31:0] smem [16];
    logic [19:0] slog [16];
    logic        p_sn, p_rnw, p_half, p_busy;
    logic [1:0]  p_sel;
    logic [15:0] p_wd;

    assign hp_busy = (busy_cnt != 0);

    always @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= 0; s_total <= 0; stab_err <= 0; width_err <= 0; r8_err <= 0;
            low_run <= 0; s_lf <= 1'b0; s_addr <= '0; hp_rdata <= '0;
            p_sn <= 1'b1; p_rnw <= 1'b1; p_half <= 1'b0; p_sel <= 2'b00; p_wd <= '0; p_busy <= 1'b0;
            for (int k = 0; k < 16; k++) smem[k] <= '0;
        end else begin
            automatic logic hi = (hp_half == s_lf);
            automatic int   ix = int'(s_addr[5:2]);
            p_sn <= hp_strobe_n; p_rnw <= hp_rnw; p_half <= hp_half; p_sel <= hp_sel;
            p_wd <= hp_wdata; p_busy <= hp_busy;
            if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
            if ((!hp_strobe_n || !p_sn) &&
                (hp_sel != p_sel || hp_rnw != p_rnw || hp_half != p_half || hp_wdata != p_wd))
                stab_err <= stab_err + 1;
            if (!hp_strobe_n) low_run <= p_sn ? 1 : low_run + 1;
            if (hp_strobe_n && !p_sn && low_run != STB) width_err <= width_err + 1;
            if (!hp_strobe_n && p_sn) begin
                if (p_busy) r8_err <= r8_err + 1;
                slog[s_total % 16] <= {2'b00, hp_sel, hp_rnw, hp_half, hp_wdata};
                s_total  <= s_total + 1;
                busy_cnt <= busy_len;
                case (hp_sel)
                    2'b00: begin
                        if (hp_rnw) hp_rdata <= {15'd0, s_lf};
                        else        s_lf <= hp_wdata[0];
                    end
                    2'b01: begin
                        if (hp_rnw) hp_rdata <= hi ? s_addr[31:16] : s_addr[15:0];
                        else if (hi) s_addr[31:16] <= hp_wdata;
                        else         s_addr[15:0]  <= hp_wdata;
                    end
                    default: begin
                        if (hp_rnw) hp_rdata <= hi ? smem[ix][31:16] : smem[ix][15:0];
                        else if (hi) smem[ix][31:16] <= hp_wdata;
                        else         smem[ix][15:0]  <= hp_wdata;
                        if (hp_sel == 2'b10 && hp_half) s_addr <= s_addr + 32'd4;
                    end
                endcase
            end
        end
    end

    // result monitor
    int          res_n, err_n;
    logic [31:0] res_buf [256];
    always @(negedge clk) begin
        if (!rst_n) begin
            res_n = 0; err_n = 0;
        end else begin
            if (res_valid) begin
                res_buf[res_n % 256] = res_data;
                res_n = res_n + 1;
            end
            if (err_timeout) err_n = err_n + 1;
        end
    end

    int n_chk, n_err;
    bit done;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    function automatic logic [19:0] pk(input logic [1:0] sel, input logic rnw,
                                       input logic half, input logic [15:0] dat);
        return {2'b00, sel, rnw, half, dat};
    endfunction

    function automatic logic [31:0] pat(input int i, input int lf);
        return 32'h1234_5678 ^ (32'(i) * 32'h0101_0101) ^ (lf != 0 ? 32'hFFFF_0000 : 32'h0000_FFFF);
    endfunction

    int base, rbase, g_res, g_str, g_cyc;
    logic [31:0] exp_mem [16];

    task automatic do_cmd(input logic [2:0] op, input logic [31:0] dat, input logic [7:0] len,
                          input bit expect_tmo);
        int words;
        words = (op == 3'd4) ? int'(len) + 1 : 1;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = dat; cmd_len = len;
        base = s_total; rbase = res_n; g_cyc = 0;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(cmd_ready == 1'b0, "R9 ready low after accept", 32'(cmd_ready), 32'd0);
        while (!cmd_ready) begin
            @(negedge clk);
            g_cyc++;
        end
        @(negedge clk);
        g_str = s_total - base;
        g_res = res_n - rbase;
        if (!expect_tmo)
            chk(g_str == 2 * words, "R9 all halves done before ready", 32'(g_str), 32'(2 * words));
    endtask

    initial begin
        logic [31:0] a;
        logic [15:0] cv;
        done = 1'b0; n_chk = 0; n_err = 0;
        cmd_valid = 1'b0; cmd_op = '0; cmd_data = '0; cmd_len = '0; busy_len = 1;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready === 1'b1, "R1 ready", 32'(cmd_ready), 32'd1);
        chk(hp_strobe_n === 1'b1, "R1 strobe idle", 32'(hp_strobe_n), 32'd1);
        chk(hp_drive === 1'b0 && res_valid === 1'b0 && err_timeout === 1'b0, "R1 outputs quiet",
            {29'd0, hp_drive, res_valid, err_timeout}, 32'd0);

        for (int lf = 1; lf >= 0; lf--) begin
            busy_len = 1;
            cv = 16'hC3A0 | 16'(lf);
            do_cmd(3'd0, {16'h0, cv}, 8'd0, 1'b0);
            chk(slog[base % 16] == pk(2'b00, 1'b0, 1'b0, cv), "R2 first control half", 32'(slog[base % 16]), 32'(pk(2'b00, 1'b0, 1'b0, cv)));
            chk(slog[(base + 1) % 16] == pk(2'b00, 1'b0, 1'b1, cv), "R2 second control half", 32'(slog[(base + 1) % 16]), 32'(pk(2'b00, 1'b0, 1'b1, cv)));
            chk(s_lf == lf[0], "R2 half order taken", 32'(s_lf), 32'(lf));

            for (int i = 0; i < 16; i++) begin
                busy_len = i % 4;
                a = 32'h8000_0000 + 32'(4 * i);
                do_cmd(3'd1, a, 8'd0, 1'b0);
                chk(slog[base % 16] == pk(2'b01, 1'b0, 1'b0, lf != 0 ? a[15:0] : a[31:16]), "R3 address first half",
                    32'(slog[base % 16]), 32'(pk(2'b01, 1'b0, 1'b0, lf != 0 ? a[15:0] : a[31:16])));
                chk(slog[(base + 1) % 16] == pk(2'b01, 1'b0, 1'b1, lf != 0 ? a[31:16] : a[15:0]), "R3 address second half",
                    32'(slog[(base + 1) % 16]), 32'(pk(2'b01, 1'b0, 1'b1, lf != 0 ? a[31:16] : a[15:0])));
                chk(s_addr == a, "R3 slave address", s_addr, a);
                exp_mem[i] = pat(i, lf);
                do_cmd(3'd2, exp_mem[i], 8'd0, 1'b0);
                chk(slog[base % 16] == pk(2'b11, 1'b0, 1'b0, lf != 0 ? exp_mem[i][15:0] : exp_mem[i][31:16]), "R4 write first half",
                    32'(slog[base % 16]), 32'(pk(2'b11, 1'b0, 1'b0, lf != 0 ? exp_mem[i][15:0] : exp_mem[i][31:16])));
                chk(smem[i] == exp_mem[i], "R4 word stored", smem[i], exp_mem[i]);
            end

            for (int i = 0; i < 16; i++) begin
                busy_len = (i + 1) % 4;
                do_cmd(3'd1, 32'h8000_0000 + 32'(4 * i), 8'd0, 1'b0);
                do_cmd(3'd3, 32'h0, 8'd0, 1'b0);
                chk(slog[base % 16][19:16] == 4'b1110 && slog[(base + 1) % 16][19:16] == 4'b1111,
                    "R5 read strobes sel/rnw/half", {24'd0, slog[base % 16][19:16], slog[(base + 1) % 16][19:16]}, 32'h0000_00EF);
                chk(g_res == 1, "R5 one result", 32'(g_res), 32'd1);
                chk(res_buf[rbase % 256] == exp_mem[i], "R5 read word", res_buf[rbase % 256], exp_mem[i]);
            end

            busy_len = 2;
            do_cmd(3'd1, 32'h8000_0000, 8'd0, 1'b0);
            do_cmd(3'd4, 32'h0, 8'd15, 1'b0);
            chk(g_res == 16, "R6 burst word count", 32'(g_res), 32'd16);
            chk(slog[base % 16][19:16] == 4'b1010, "R6 burst select and direction", 32'(slog[base % 16][19:16]), 32'hA);
            for (int k = 0; k < 16; k++)
                chk(res_buf[(rbase + k) % 256] == exp_mem[k], "R6 burst word", res_buf[(rbase + k) % 256], exp_mem[k]);
            chk(s_addr == 32'h8000_0040, "R6 address advanced", s_addr, 32'h8000_0040);

            do_cmd(3'd1, 32'h8000_0020, 8'd0, 1'b0);
            do_cmd(3'd4, 32'h0, 8'd0, 1'b0);
            chk(g_res == 1, "R6 single-word burst count", 32'(g_res), 32'd1);
            chk(res_buf[rbase % 256] == exp_mem[8], "R6 single-word burst data", res_buf[rbase % 256], exp_mem[8]);
        end

        busy_len = 0;
        do_cmd(3'd1, 32'h0, 8'd0, 1'b0);
        do_cmd(3'd4, 32'h0, 8'd255, 1'b0);
        chk(g_res == 256, "R6 longest burst count", 32'(g_res), 32'd256);
        for (int k = 0; k < 256; k++)
            if (res_buf[(rbase + k) % 256] != exp_mem[k % 16])
                chk(1'b0, "R6 longest burst word", res_buf[(rbase + k) % 256], exp_mem[k % 16]);
        chk(1'b1, "R6 longest burst words", 32'd0, 32'd0);

        chk(width_err == 0, "R7 strobe width", 32'(width_err), 32'd0);
        chk(stab_err == 0, "R7 bus stability", 32'(stab_err), 32'd0);
        chk(r8_err == 0, "R8 no strobe after busy", 32'(r8_err), 32'd0);

        busy_len = TMO + 100;
        a = 32'(err_n);
        do_cmd(3'd3, 32'h0, 8'd0, 1'b1);
        chk(err_n - int'(a) == 1, "R10 one timeout pulse", 32'(err_n - int'(a)), 32'd1);
        chk(g_res == 0, "R10 no result", 32'(g_res), 32'd0);
        chk(g_str == 1, "R10 no second strobe", 32'(g_str), 32'd1);
        chk(g_cyc >= TMO, "R10 waited the limit", 32'(g_cyc), 32'(TMO));
        chk(cmd_ready == 1'b1, "R10 back to idle", 32'(cmd_ready), 32'd1);
        busy_len = 1;
        repeat (TMO + 120) @(negedge clk);
        do_cmd(3'd3, 32'h0, 8'd0, 1'b0);
        chk(g_res == 1, "R10 recovers after timeout", 32'(g_res), 32'd1);

        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end
endmodule